// File: doc/BRIEF.md
# Differential Pair Decoder

This block turns one differential wire pair into a single-ended level. Alongside the level it produces single-cycle rise and fall strobes, an event strobe for either edge, and an integrity error flag. The flag is raised when both wires carry the same value. While the pair is not complementary, the decoded level keeps its last good value and no strobe is issued. A consumer can therefore treat every event strobe as a clean request.

A compile-time switch selects one of two variants. In the synchronous variant the pair shares the clock domain. The error flag and the strobes follow the wires combinationally, so they are visible before the next clock edge. In the asynchronous variant each wire first passes through a two-flop synchronizer. An equal-wire condition must then be seen on consecutive synchronized samples before it is flagged. A one-sample skew during a legal transition therefore only holds the level and raises no error.

Top module: `diffpair_decoder`

## Requirements
- R1: With ASYNC_MODE=0, `err_o` is 1 in every cycle in which `pos_i` equals `neg_i`, and 0 in every cycle in which they differ.
- R2: With ASYNC_MODE=0, while `pos_i` differs from `neg_i`, `level_o` equals `pos_i` in the same cycle.
- R3: While the (synchronized) pair is not complementary, `level_o` holds the level stored at the last clock edge, and `rise_o`, `fall_o` and `event_o` are 0.
- R4: `rise_o` is 1 for exactly the cycles in which the pair is complementary, its positive wire is 1 and the stored level is 0. After such a cycle the stored level is 1.
- R5: `fall_o` is 1 for exactly the cycles in which the pair is complementary, its positive wire is 0 and the stored level is 1. After such a cycle the stored level is 0.
- R6: `event_o` is 1 exactly when `rise_o` or `fall_o` is 1.
- R7: With ASYNC_MODE=1, `err_o` is 1 only once the synchronized pair has been equal on two consecutive clock edges. A pair driven equal from idle shows `err_o`=1 after the third clock edge and not earlier. An equal pair that lasts for a single cycle never sets `err_o`.
- R8: With ASYNC_MODE=1, a change on a complementary pair reaches `level_o` and the strobes after two clock edges.
- R9: While reset is held low with the pair idle (`pos_i`=0, `neg_i`=1), `level_o`, `rise_o`, `fall_o`, `event_o` and `err_o` are all 0. The stored level and both synchronizer stages reset to the idle pair.
- R10: `rise_o` and `fall_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pos_i | input | 1 | Positive wire of the pair |
| neg_i | input | 1 | Negative wire of the pair |
| level_o | output | 1 | Decoded level, held during a non-complementary pair |
| rise_o | output | 1 | Single-cycle strobe on a 0-to-1 level change |
| fall_o | output | 1 | Single-cycle strobe on a 1-to-0 level change |
| event_o | output | 1 | Strobe on either level change |
| err_o | output | 1 | Integrity error: wires carry the same value |

## Verification
Both variants are driven from the same wires. A near-exhaustive sweep covers every ordered pair of the four wire codes, with the first code held for one, two and three cycles. This separates an equal pair lasting one sample (level held, no flag in asynchronous mode) from one that persists (flag raised). It also separates a direct 0-to-1 swap from one that passes through an equal state. A long pseudo-random run with random hold lengths follows, which mixes edges with integrity errors at every phase. Directed sequences pin the exact cycle of the asynchronous flag and the reset values.

// File: rtl/diffdec_pkg.sv
package diffdec_pkg;

  // persistence (in synchronized samples) required before an equal pair is flagged
  localparam int unsigned PERSIST_SAMPLES = 2;

  // synchronizer depth used by the asynchronous variant
  localparam int unsigned SYNC_DEPTH = 2;

  function automatic logic pair_ok(input logic p, input logic n);
    return p ^ n;
  endfunction

  function automatic logic edge_up(input logic ok, input logic cur, input logic prev);
    return ok & cur & ~prev;
  endfunction

  function automatic logic edge_down(input logic ok, input logic cur, input logic prev);
    return ok & ~cur & prev;
  endfunction

endpackage

// File: rtl/diffdec_sync.sv
module diffdec_sync #(
  parameter int unsigned DEPTH = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] chain_q;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q[s] <= RST_VAL;
      end else if (s == 0) begin
        chain_q[s] <= d_i;
      end else begin
        chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = chain_q[DEPTH-1];
endmodule

// File: rtl/diffdec_integrity.sv
module diffdec_integrity
  import diffdec_pkg::*;
#(
  parameter bit          ASYNC_MODE = 1'b0,
  parameter int unsigned PERSIST    = PERSIST_SAMPLES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic p_i,
  input  logic n_i,
  output logic valid_o,
  output logic err_o
);
  localparam int unsigned CW = $clog2(PERSIST + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(PERSIST);
  // synchronous: flag at once; asynchronous: after PERSIST equal samples
  localparam logic [CW-1:0] THRESH = ASYNC_MODE ? CW'(PERSIST - 1) : '0;

  logic          equal_now;
  logic [CW-1:0] eq_cnt_q;

  assign valid_o   = pair_ok(p_i, n_i);
  assign equal_now = ~valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eq_cnt_q <= '0;
    end else if (!equal_now) begin
      eq_cnt_q <= '0;
    end else if (eq_cnt_q != CNT_MAX) begin
      eq_cnt_q <= eq_cnt_q + 1'b1;
    end
  end

  assign err_o = equal_now && (eq_cnt_q >= THRESH);

  if (ASYNC_MODE) begin : g_async_chk
    // R7: a flag needs the equal condition on the previous sample too
    assert_persist_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> $past(p_i == n_i));
  end else begin : g_sync_chk
    // R1: flag tracks the wires in the same cycle
    assert_flag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (p_i == n_i) |-> err_o);
  end
endmodule

// File: rtl/diffdec_edge.sv
module diffdec_edge
  import diffdec_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic sample_i,
  output logic level_o,
  output logic prev_o,
  output logic rise_o,
  output logic fall_o,
  output logic evt_o
);
  logic prev_q;

  assign level_o = valid_i ? sample_i : prev_q;
  assign rise_o  = edge_up(valid_i, sample_i, prev_q);
  assign fall_o  = edge_down(valid_i, sample_i, prev_q);
  assign evt_o   = rise_o | fall_o;
  assign prev_o  = prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_o;
  end

  // R3: held level and quiet strobes on a bad pair
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (level_o == prev_q) && !evt_o);
  // R4: a rise leaves the stored level at 1
  assert_rise_store_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> prev_q);
  // R5: a fall leaves the stored level at 0
  assert_fall_store_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !prev_q);
  // R10: strobes are exclusive
  assert_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
endmodule

// File: rtl/diffpair_decoder.sv
module diffpair_decoder
  import diffdec_pkg::*;
#(
  parameter bit ASYNC_MODE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pos_i,
  input  logic neg_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o,
  output logic event_o,
  output logic err_o
);
  logic p_s, n_s;
  logic pair_valid;
  logic stored_lvl;

  if (ASYNC_MODE) begin : g_sync
    diffdec_sync #(.DEPTH(SYNC_DEPTH), .RST_VAL(1'b0)) u_sync_p (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pos_i), .q_o(p_s));
    diffdec_sync #(.DEPTH(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync_n (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(neg_i), .q_o(n_s));
  end else begin : g_direct
    assign p_s = pos_i;
    assign n_s = neg_i;
  end

  diffdec_integrity #(.ASYNC_MODE(ASYNC_MODE), .PERSIST(PERSIST_SAMPLES)) u_integ (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .p_i     (p_s),
    .n_i     (n_s),
    .valid_o (pair_valid),
    .err_o   (err_o)
  );

  diffdec_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (pair_valid),
    .sample_i (p_s),
    .level_o  (level_o),
    .prev_o   (stored_lvl),
    .rise_o   (rise_o),
    .fall_o   (fall_o),
    .evt_o    (event_o)
  );

  // R6: an event is always backed by a change against the stored level
  assert_event_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> (level_o != stored_lvl));
  // R3: an error never coincides with a strobe
  assert_err_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !event_o);

  if (!ASYNC_MODE) begin : g_sync_lvl_chk
    // R2: a good pair drives the level directly
    assert_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pos_i ^ neg_i) |-> (level_o == pos_i));
  end
endmodule

// File: tb/sim_diffpair_decoder.sv
module sim_diffpair_decoder;
  localparam time PERIOD = 8ns;
  localparam int  MAX_CYC = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pw = 1'b0;
  logic nw = 1'b1;

  logic s_lvl, s_rise, s_fall, s_evt, s_err;
  logic a_lvl, a_rise, a_fall, a_evt, a_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  diffpair_decoder #(.ASYNC_MODE(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pos_i(pw), .neg_i(nw),
    .level_o(s_lvl), .rise_o(s_rise), .fall_o(s_fall), .event_o(s_evt), .err_o(s_err));

  diffpair_decoder #(.ASYNC_MODE(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .pos_i(pw), .neg_i(nw),
    .level_o(a_lvl), .rise_o(a_rise), .fall_o(a_fall), .event_o(a_evt), .err_o(a_err));

  // ---------------- bench-side reference state ----------------
  bit m_slvl;                  // synchronous variant stored level
  bit m_p1, m_p2, m_n1, m_n2;  // asynchronous variant delayed wires
  int m_eqrun;                 // consecutive equal synchronized samples
  bit m_alvl;                  // asynchronous variant stored level

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_slvl = 0; m_p1 = 0; m_p2 = 0; m_n1 = 1; m_n2 = 1; m_eqrun = 0; m_alvl = 0;
    end else begin
      if (pw != nw) m_slvl = pw;
      if (m_p2 != m_n2) begin m_alvl = m_p2; m_eqrun = 0; end
      else m_eqrun = m_eqrun + 1;
      m_p2 = m_p1; m_n2 = m_n1; m_p1 = pw; m_n1 = nw;
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare both variants against the reference; called away from posedge
  task automatic compare_all();
    bit ok, el, er, ef;
    ok = (pw != nw);
    el = ok ? pw : m_slvl;
    er = ok && pw && !m_slvl;
    ef = ok && !pw && m_slvl;
    chk("R1", "sync err", s_err, !ok);
    chk(ok ? "R2" : "R3", "sync level", s_lvl, el);
    chk("R4", "sync rise", s_rise, er);
    chk("R5", "sync fall", s_fall, ef);
    chk("R6", "sync event", s_evt, er | ef);
    chk("R10", "sync excl", s_rise & s_fall, 1'b0);
    ok = (m_p2 != m_n2);
    el = ok ? m_p2 : m_alvl;
    er = ok && m_p2 && !m_alvl;
    ef = ok && !m_p2 && m_alvl;
    chk("R7", "async err", a_err, !ok && (m_eqrun >= 1));
    chk("R8", "async level", a_lvl, el);
    chk("R8", "async rise", a_rise, er);
    chk("R8", "async fall", a_fall, ef);
    chk("R6", "async event", a_evt, er | ef);
    chk("R10", "async excl", a_rise & a_fall, 1'b0);
  endtask

  // one cycle: change wires after the negedge, compare before the posedge
  task automatic step(input logic p, input logic n);
    @(negedge clk);
    pw = p; nw = n;
    #1;
    compare_all();
  endtask

  task automatic idle(input int cyc);
    for (int i = 0; i < cyc; i++) step(1'b0, 1'b1);
  endtask

  initial begin : watchdog
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lfsr;
    // R9: reset state with idle pair
    repeat (3) @(negedge clk);
    chk("R9", "sync level", s_lvl, 1'b0);
    chk("R9", "sync strobes", s_rise | s_fall | s_evt, 1'b0);
    chk("R9", "sync err", s_err, 1'b0);
    chk("R9", "async level", a_lvl, 1'b0);
    chk("R9", "async strobes", a_rise | a_fall | a_evt, 1'b0);
    chk("R9", "async err", a_err, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R7 directed: equal pair from idle flagged after the third edge
    @(negedge clk); pw = 1; nw = 1; #1;
    chk("R1", "sync err immediate", s_err, 1'b1);
    @(negedge clk); chk("R7", "async err after 1 edge", a_err, 1'b0);
    @(negedge clk); chk("R7", "async err after 2 edges", a_err, 1'b0);
    @(negedge clk); chk("R7", "async err after 3 edges", a_err, 1'b1);
    chk("R3", "async level held", a_lvl, 1'b0);
    idle(5);

    // R7 directed: one-cycle equal pair never flags
    @(negedge clk); pw = 1; nw = 1;
    @(negedge clk); pw = 0; nw = 1;
    begin
      bit seen = 0;
      for (int i = 0; i < 5; i++) begin @(negedge clk); seen |= a_err; end
      chk("R7", "async single-sample glitch", seen, 1'b0);
    end

    // R8 directed: rise reaches async outputs after two edges
    @(negedge clk); pw = 1; nw = 0; #1;
    chk("R4", "sync rise same cycle", s_rise, 1'b1);
    @(negedge clk); chk("R8", "async rise after 1 edge", a_rise, 1'b0);
    chk("R4", "sync rise single pulse", s_rise, 1'b0);
    @(negedge clk); chk("R8", "async rise after 2 edges", a_rise, 1'b1);
    @(negedge clk); chk("R8", "async rise single pulse", a_rise, 1'b0);
    idle(4);

    // near-exhaustive sweep: code a held h cycles, then code b, then idle
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int h = 1; h <= 3; h++) begin
          for (int k = 0; k < h; k++) step(a[1], a[0]);
          for (int k = 0; k < 3; k++) step(b[1], b[0]);
          for (int k = 0; k < 4; k++) step(1'b1, 1'b0);
          idle(4);
        end

    // pseudo-random run with random hold lengths
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      for (int k = 0; k <= int'(lfsr[4:3]); k++) step(lfsr[1], lfsr[0]);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule